// File: doc/BRIEF.md
# Shared-Line Interrupt Router

The router takes eight level-sensitive device interrupt lines and one power-management event line (the SCI) and fans them out to two interrupt controllers at once. It drives sixteen legacy PIC lines and twenty-four IOAPIC global interrupt lines. Each device line has a programmable route byte that picks one PIC line or disables the PIC path. Several device lines can share one PIC line, and that line's level is the OR of all enabled sources routed to it. On the IOAPIC side the mapping is fixed and never shared: device line n always drives global line 16 + n.

A small byte-wide write port with a combinational read-back holds the eight route bytes and one SCI control byte. The SCI control byte picks which global line carries the SCI. That line is one of 9, 10, 11, 20 or 21, or none for a reserved code. The SCI also reaches the PIC when the selected line is below 16. The router also reports the effective destination of every device line, so that downstream routing tables can be kept coherent.

Device and SCI inputs are sampled by one register stage. The outputs are combinational from that stage and from the configuration registers, so every input or configuration change appears at the outputs one clock later.

Top module: `irq_router`

## Requirements
- R1: Address n (0 to 7) holds the route byte of device line n. Bits 3:0 of that byte are the PIC line and bit 7 is the disable flag (1 = disabled). Address 8 holds the SCI control byte. `cfg_rdata_o` returns the full byte at `cfg_addr_i` combinationally. Addresses 9 to 15 read as 0, and writes to them change no register.
- R2: One cycle after the inputs, `pic_o[k]` is the OR of every enabled device line whose route byte names PIC line k. The SCI term of R5 is added to this.
- R3: A device line whose disable flag is set contributes to no PIC line.
- R4: One cycle after the inputs, `gsi_o[16+n]` equals `pirq_i[n]` ORed with the SCI when the SCI selects that line, whatever the route bytes hold. `gsi_o[15:0]` is driven only by the SCI.
- R5: SCI control bits 2:0 select the SCI line. Code 0 selects line 9, 1 selects 10, 2 selects 11, 3 selects 20 and 4 selects 21. Codes 5 to 7 route the SCI nowhere. The stored SCI level is ORed into the selected global line, and into the PIC line of the same number only when that number is below 16.
- R6: The SCI level is stored by one register and reaches the outputs one cycle after `sci_i`. Holding `sci_i` at the stored level leaves every output unchanged.
- R7: `route_valid_o[n]` is 1. For an enabled line, `route_line_o[5n+4:5n]` is the PIC line from its route byte. For a disabled line, it is 16 + n.
- R8: Reset sets all route bytes to 0x80, sets the SCI control byte to 0x00, and clears the stored SCI and device levels, so every PIC and global output is low.
- R9: A configuration write changes the outputs from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pirq_i | input | 8 | Device interrupt levels, line n at bit n |
| sci_i | input | 1 | SCI level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Read-back of the addressed byte |
| pic_o | output | 16 | Legacy PIC line levels |
| gsi_o | output | 24 | IOAPIC global interrupt levels |
| route_valid_o | output | 8 | Effective route of device line n is usable |
| route_line_o | output | 40 | Effective destination line of each device line, 5 bits each |

## Verification
A corrupted route byte shows up on the very next cycle in two places. The read-back value changes, and so does the reported destination, even with every input low. It also moves a device's level to the wrong PIC line as soon as that device is driven. A stale sampled device or SCI level appears one cycle after the input change as a global or PIC line that fails to follow. For that reason every input step is compared cycle by cycle against a model of all outputs, under random route tables and all eight SCI codes.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int BYTE_W      = 8;
  localparam int PIC_FIELD_W = 4;
  localparam int DIS_BIT     = 7;
  localparam int SEL_W       = 3;
  localparam int SCI_LINE_W  = 5;

  localparam logic [BYTE_W-1:0] ROUTE_RESET    = 8'h80;
  localparam logic [BYTE_W-1:0] SCI_CTRL_RESET = 8'h00;

  typedef struct packed {
    logic                  valid;
    logic [SCI_LINE_W-1:0] line;
  } line_sel_t;

  function automatic line_sel_t sci_decode(input logic [SEL_W-1:0] code);
    line_sel_t r;
    r.valid = 1'b1;
    case (code)
      3'd0:    r.line = 5'd9;
      3'd1:    r.line = 5'd10;
      3'd2:    r.line = 5'd11;
      3'd3:    r.line = 5'd20;
      3'd4:    r.line = 5'd21;
      default: begin r.valid = 1'b0; r.line = '0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [BYTE_W-1:0]                  wdata_i,
  output logic [BYTE_W-1:0]                  rdata_o,
  output logic [NUM_PIRQ-1:0][BYTE_W-1:0]    route_o,
  output logic [BYTE_W-1:0]                  sci_ctrl_o
);
  localparam logic [ADDR_W-1:0] SCI_ADDR = ADDR_W'(NUM_PIRQ);

  logic [NUM_PIRQ-1:0][BYTE_W-1:0] route_q;
  logic [BYTE_W-1:0]               sci_ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_PIRQ; n++) route_q[n] <= ROUTE_RESET;
      sci_ctrl_q <= SCI_CTRL_RESET;
    end else if (we_i) begin
      for (int n = 0; n < NUM_PIRQ; n++)
        if (addr_i == ADDR_W'(n)) route_q[n] <= wdata_i;
      if (addr_i == SCI_ADDR) sci_ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_PIRQ; n++)
      if (addr_i == ADDR_W'(n)) rdata_o = route_q[n];
    if (addr_i == SCI_ADDR) rdata_o = sci_ctrl_q;
  end

  assign route_o    = route_q;
  assign sci_ctrl_o = sci_ctrl_q;

  // R1: out-of-map writes leave every register untouched
  a_r1_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > SCI_ADDR) |=> ($stable(route_q) && $stable(sci_ctrl_q)));
endmodule

// File: rtl/irq_route_sci.sv
`timescale 1ns/1ps
module irq_route_sci
  import irq_route_pkg::*;
#(
  parameter int NUM_GSI = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sci_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_GSI-1:0] sci_hit_o
);
  logic      sci_q;
  logic      live_q;
  line_sel_t dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sci_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      sci_q  <= sci_i;
      live_q <= 1'b1;
    end
  end

  assign dec = sci_decode(sel_i);

  always_comb
    for (int g = 0; g < NUM_GSI; g++)
      sci_hit_o[g] = sci_q & dec.valid & (int'(dec.line) == g);

  // R6: stored level is the previous cycle's input
  a_r6_sci_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (sci_q == $past(sci_i)));
endmodule

// File: rtl/irq_route_fanin.sv
`timescale 1ns/1ps
module irq_route_fanin
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int NUM_PIC  = 16,
  parameter int NUM_GSI  = 24,
  parameter int LINE_W   = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PIRQ-1:0]             pirq_i,
  input  logic [NUM_PIRQ-1:0][BYTE_W-1:0] route_i,
  input  logic [NUM_GSI-1:0]              sci_hit_i,
  output logic [NUM_PIC-1:0]              pic_o,
  output logic [NUM_GSI-1:0]              gsi_o,
  output logic [NUM_PIRQ-1:0]             route_valid_o,
  output logic [NUM_PIRQ*LINE_W-1:0]      route_line_o
);
  logic [NUM_PIRQ-1:0] pirq_q;
  logic [NUM_PIRQ-1:0] en;
  logic [NUM_PIRQ-1:0] dis;
  logic                live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pirq_q <= '0;
      live_q <= 1'b0;
    end else begin
      pirq_q <= pirq_i;
      live_q <= 1'b1;
    end
  end

  always_comb
    for (int n = 0; n < NUM_PIRQ; n++) begin
      dis[n] = route_i[n][DIS_BIT];
      en[n]  = pirq_q[n] & ~dis[n];
    end

  // shared PIC lines: wired-OR of enabled sources plus SCI below NUM_PIC
  always_comb begin
    pic_o = sci_hit_i[NUM_PIC-1:0];
    for (int l = 0; l < NUM_PIC; l++)
      for (int n = 0; n < NUM_PIRQ; n++)
        if (en[n] && int'(route_i[n][PIC_FIELD_W-1:0]) == l) pic_o[l] = 1'b1;
  end

  // fixed, unshared APIC lines
  assign gsi_o = sci_hit_i | {pirq_q, {NUM_PIC{1'b0}}};

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_rep
    logic [PIC_FIELD_W-1:0] fld;
    logic                   v;
    logic [LINE_W-1:0]      ln;
    assign fld = route_i[n][PIC_FIELD_W-1:0];
    if ((1 << PIC_FIELD_W) > NUM_PIC) begin : g_chk
      always_comb begin
        if (dis[n]) begin
          v = 1'b1; ln = LINE_W'(NUM_PIC + n);
        end else if (int'(fld) < NUM_PIC) begin
          v = 1'b1; ln = LINE_W'(fld);
        end else begin
          v = 1'b0; ln = '0;
        end
      end
    end else begin : g_full
      always_comb begin
        v  = 1'b1;
        ln = dis[n] ? LINE_W'(NUM_PIC + n) : LINE_W'(fld);
      end
    end
    assign route_valid_o[n]               = v;
    assign route_line_o[n*LINE_W +: LINE_W] = ln;

    // R4: device level reaches its own global line one cycle later
    a_r4_gsi_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(pirq_i[n])) |-> gsi_o[NUM_PIC+n]);
  end

  logic unused_route_bits;
  always_comb begin
    unused_route_bits = 1'b0;
    for (int n = 0; n < NUM_PIRQ; n++)
      unused_route_bits ^= ^route_i[n][DIS_BIT-1:PIC_FIELD_W];
  end

  // R2: nothing asserted on the PIC without a source
  a_r2_pic_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pirq_q == '0 && sci_hit_i[NUM_PIC-1:0] == '0) |-> (pic_o == '0));
  // R3: fully disabled table keeps PIC idle apart from SCI
  a_r3_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dis && sci_hit_i[NUM_PIC-1:0] == '0) |-> (pic_o == '0));
  // R4: only the SCI can reach the low global lines
  a_r4_gsi_low_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gsi_o[NUM_PIC-1:0]));
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int NUM_PIC  = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_PIRQ-1:0]          pirq_i,
  input  logic                         sci_i,
  input  logic                         cfg_we_i,
  input  logic [ADDR_W-1:0]            cfg_addr_i,
  input  logic [7:0]                   cfg_wdata_i,
  output logic [7:0]                   cfg_rdata_o,
  output logic [NUM_PIC-1:0]           pic_o,
  output logic [NUM_PIC+NUM_PIRQ-1:0]  gsi_o,
  output logic [NUM_PIRQ-1:0]          route_valid_o,
  output logic [NUM_PIRQ*$clog2(NUM_PIC+NUM_PIRQ)-1:0] route_line_o
);
  localparam int NUM_GSI = NUM_PIC + NUM_PIRQ;
  localparam int LINE_W  = $clog2(NUM_GSI);

  logic [NUM_PIRQ-1:0][BYTE_W-1:0] route;
  logic [BYTE_W-1:0]               sci_ctrl;
  logic [NUM_GSI-1:0]              sci_hit;
  logic                            unused_ctrl;

  irq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .route_o    (route),
    .sci_ctrl_o (sci_ctrl)
  );

  irq_route_sci #(.NUM_GSI(NUM_GSI)) u_sci (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sci_i     (sci_i),
    .sel_i     (sci_ctrl[SEL_W-1:0]),
    .sci_hit_o (sci_hit)
  );

  irq_route_fanin #(
    .NUM_PIRQ (NUM_PIRQ),
    .NUM_PIC  (NUM_PIC),
    .NUM_GSI  (NUM_GSI),
    .LINE_W   (LINE_W)
  ) u_fanin (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pirq_i        (pirq_i),
    .route_i       (route),
    .sci_hit_i     (sci_hit),
    .pic_o         (pic_o),
    .gsi_o         (gsi_o),
    .route_valid_o (route_valid_o),
    .route_line_o  (route_line_o)
  );

  assign unused_ctrl = ^sci_ctrl[BYTE_W-1:SEL_W];

  // R5: reserved select codes keep the SCI off every low global line
  a_r5_sci_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sci_ctrl[SEL_W-1:0] > 3'd4) |-> (gsi_o[NUM_PIC-1:0] == '0 && sci_hit == '0));
endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pirq = '0;
  logic        sci = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pic;
  logic [23:0] gsi;
  logic [7:0]  rvalid;
  logic [39:0] rline;

  always #2.5 clk = ~clk;

  irq_router dut (
    .clk_i(clk), .rst_ni(rst_n), .pirq_i(pirq), .sci_i(sci),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .pic_o(pic), .gsi_o(gsi), .route_valid_o(rvalid), .route_line_o(rline)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_route [NP];
  logic [7:0] m_ctrl;
  logic [7:0] m_pirq;
  logic       m_sci;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic int sci_line(input logic [2:0] c);
    case (c)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd3: return 20;
      3'd4: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] exp_pic();
    logic [15:0] p = '0;
    int s;
    for (int n = 0; n < NP; n++)
      if (!m_route[n][7] && m_pirq[n]) p[m_route[n][3:0]] = 1'b1;
    s = sci_line(m_ctrl[2:0]);
    if (m_sci && s >= 0 && s < 16) p[s] = 1'b1;
    return p;
  endfunction

  function automatic logic [23:0] exp_gsi();
    logic [23:0] g = {m_pirq, 16'h0000};
    int s;
    s = sci_line(m_ctrl[2:0]);
    if (m_sci && s >= 0) g[s] = 1'b1;
    return g;
  endfunction

  function automatic logic [39:0] exp_lines();
    logic [39:0] r = '0;
    for (int n = 0; n < NP; n++)
      r[n*5 +: 5] = m_route[n][7] ? 5'(16 + n) : {1'b0, m_route[n][3:0]};
    return r;
  endfunction

  task automatic model_reset();
    for (int n = 0; n < NP; n++) m_route[n] = 8'h80;
    m_ctrl = 8'h00; m_pirq = '0; m_sci = 1'b0;
  endtask

  task automatic chk_out(input string req);
    chk({req, " pic"}, pic, exp_pic());
    chk({req, " gsi"}, gsi, exp_gsi());
  endtask

  task automatic chk_route(input string req);
    chk({req, " valid"}, rvalid, 8'hFF);
    chk({req, " line"}, rline, exp_lines());
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic [7:0] p, input logic s);
    pirq = p; sci = s;
    @(negedge clk);
    m_pirq = p; m_sci = s;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a < 4'(NP)) m_route[a] = d;
    else if (a == 4'(NP)) m_ctrl = d;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    logic [7:0] e;
    addr = a;
    #0.5;
    if (a < 4'(NP)) e = m_route[a];
    else if (a == 4'(NP)) e = m_ctrl;
    else e = 8'h00;
    chk(req, rdata, e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pirq = '0; sci = 1'b0; we = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 16; a++) rd(4'(a), req);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R8 reset state
    chk_out("R8 reset");
    chk_route("R8 reset route");
    read_all("R8/R1 reset readback");

    // R4: default table is fully disabled, global lines still follow
    cyc(8'hA5, 1'b0);
    chk_out("R4 disabled table");
    chk("R3 no PIC when disabled", pic, 16'h0000);

    // R1/R2/R9: shared PIC line
    wr(4'd0, 8'h05);
    wr(4'd1, 8'h05);
    wr(4'd2, 8'h0A);
    chk_route("R9 route after write");
    read_all("R1 readback");
    cyc(8'h01, 1'b0); chk_out("R2 single source");
    cyc(8'h02, 1'b0); chk_out("R2 second sharer");
    chk("R2 shared line 5", pic, 16'h0020);
    cyc(8'h04, 1'b0); chk_out("R2 line 10");
    cyc(8'h07, 1'b0); chk_out("R2 three sources");
    cyc(8'h00, 1'b0); chk_out("R2 idle");

    // R3: disabling one sharer
    wr(4'd1, 8'h85);
    cyc(8'h02, 1'b0);
    chk_out("R3 disabled sharer");
    chk("R3 disabled sharer pic", pic, 16'h0000);
    chk_route("R7 disabled reports apic line");

    // R5: every SCI select code
    for (int c = 0; c < 8; c++) begin
      wr(4'd8, 8'(c));
      cyc(8'h00, 1'b1); chk_out("R5 sci select");
      cyc(8'h00, 1'b0); chk_out("R5 sci release");
    end

    // R6: SCI latency and hold
    wr(4'd8, 8'h01);
    sci = 1'b1;
    #0.5;
    chk("R6 no same-cycle effect", gsi[10], 1'b0);
    @(negedge clk); m_sci = 1'b1;
    chk_out("R6 one cycle later");
    cyc(8'h00, 1'b1); chk_out("R6 hold unchanged");
    cyc(8'h00, 1'b1); chk_out("R6 hold unchanged again");
    cyc(8'h00, 1'b0);

    // R1: writes outside the map are ignored
    wr(4'd9, 8'h11);
    wr(4'd15, 8'h22);
    read_all("R1 ignored write");
    chk_route("R1 route unchanged");

    // random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 4 == 0) wr(4'($urandom % 16), 8'($urandom));
      cyc(8'($urandom), 1'($urandom));
      chk_out("R2/R4/R5 random");
      if (i % 16 == 0) chk_route("R7 random");
    end
    read_all("R1 random readback");

    // R8 mid-run reset
    wr(4'd3, 8'h02);
    wr(4'd8, 8'h03);
    cyc(8'hFF, 1'b1);
    do_reset();
    chk_out("R8 mid-run reset");
    chk_route("R8 mid-run route");
    read_all("R8 mid-run readback");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule